// File: doc/BRIEF.md
# Dataflow Synchronizing Register File

This block is the register store of a multithreaded core in which every entry holds a small synchronization cell next to its data word. The cell has four states: empty, pending, waiting and full. A waiting entry keeps the head and tail thread IDs of the threads suspended on it, and each entry also carries a load-pending tag. Writers update the state, data, thread list and tag in a single write. The block checks each write against the legal transitions. When a write fills a waiting register, the block asks the scheduler to wake that register's thread list.

There are two banks, one for integers and one for floats, and a bank bit in every address selects between them. Each bank has its own depth. Several write ports are checked in parallel during a cycle, and all accepted writes take effect together at the next clock edge. One combinational read port returns the whole cell. Illegal writes are refused and set sticky error flags, which the system can inspect. Scheduling, memory and arithmetic units lie outside the block.

Top module: `dfsync_regfile`

## Requirements
- R1: After reset every entry in both banks reads state EMPTY (code 0), data 0, head and tail all ones (the "no thread" ID) and tag 0, and the three error flags are low. The state codes are EMPTY=0, PENDING=1, WAITING=2 and FULL=3.
- R2: The read port is combinational and returns the state, data, head, tail and tag of the entry addressed by `rd_bank` (0 selects the integer bank, 1 the float bank) and `rd_index`. An index at or beyond that bank's depth reads as the reset cell.
- R3: A write accepted in a cycle (`wr_accept` high) is stored at the next rising edge, and all ports commit in that same edge. A refused write changes nothing.
- R4: A FULL write to a WAITING entry whose head is not all ones raises `wake_valid` in the same cycle, carrying the entry's stored head and tail. The write is accepted only if `wake_ready` is high; otherwise it is refused with no error. When several ports need a wake-up, the lowest-numbered port owns the request and the others are refused.
- R5: A write of EMPTY or PENDING whose head is not all ones is refused and sets `err_proto`.
- R6: A write of EMPTY to an entry in state WAITING is refused and sets `err_proto`.
- R7: When a non-FULL entry holds a non-zero tag, a write whose `wr_from_mem` bit is low is refused and sets `err_proto` if it writes FULL or a tag different from the stored one. The same write with `wr_from_mem` high is allowed.
- R8: A write whose index is at or beyond its bank's depth is refused, sets `err_range`, and changes no entry.
- R9: When two valid writes in one cycle name the same bank and index, the higher-numbered port is refused and sets `err_dup`. The lower-numbered port is judged as if it were alone.
- R10: Once set, the error flags stay high until reset.
- R11: The checks in R6 and R7 do not apply when the stored state is FULL. Such a write is accepted unless R5, R8 or R9 refuses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | NWP | Write request per port |
| wr_bank | input | NWP | Bank select per port, 0 integer, 1 float |
| wr_index | input | NWP x IW | Entry index per port |
| wr_state | input | NWP x 2 | New state code per port |
| wr_data | input | NWP x DATA_W | New data word per port |
| wr_head | input | NWP x TID_W | New waiting-list head per port |
| wr_tail | input | NWP x TID_W | New waiting-list tail per port |
| wr_meta | input | NWP x META_W | New load-pending tag per port |
| wr_from_mem | input | NWP | Write originates from the memory return path |
| wr_accept | output | NWP | Write is taken this cycle |
| wake_valid | output | 1 | Wake-up request for a thread list |
| wake_ready | input | 1 | Scheduler takes the wake-up request |
| wake_head | output | TID_W | First thread of the list to wake |
| wake_tail | output | TID_W | Last thread of the list to wake |
| rd_bank | input | 1 | Read bank select |
| rd_index | input | IW | Read entry index |
| rd_state | output | 2 | State of the addressed entry |
| rd_data | output | DATA_W | Data of the addressed entry |
| rd_head | output | TID_W | Waiting-list head of the addressed entry |
| rd_tail | output | TID_W | Waiting-list tail of the addressed entry |
| rd_meta | output | META_W | Load-pending tag of the addressed entry |
| err_range | output | 1 | Sticky: out-of-range write seen |
| err_dup | output | 1 | Sticky: same-address write collision seen |
| err_proto | output | 1 | Sticky: illegal transition or tag change seen |

## Verification
Several properties are checked on every cycle. The error flags never fall once they are set. A wake-up never carries the "no thread" head. Two accepted writes never share an address. An accepted EMPTY or PENDING write always carries the empty head. A port-0 commit is visible on an unchanged read address one cycle later. Some behaviour can only be shown by the bench's scenarios against its own model. These include the exact refusal reasons, such as the tag rule with and without the memory bit, the waiting-to-empty ban, and the bypass for FULL entries. They also include refusal while the scheduler is not ready, which lowest port wins the wake-up, and the reset-cell value for out-of-range reads.

// File: rtl/dfsync_pkg.sv
package dfsync_pkg;
  parameter int DATA_W = 32;
  parameter int TID_W  = 4;
  parameter int META_W = 4;

  typedef enum logic [1:0] {
    ST_EMPTY   = 2'd0,
    ST_PENDING = 2'd1,
    ST_WAITING = 2'd2,
    ST_FULL    = 2'd3
  } sync_st_e;

  typedef struct packed {
    sync_st_e            st;
    logic [DATA_W-1:0]   data;
    logic [TID_W-1:0]    head;
    logic [TID_W-1:0]    tail;
    logic [META_W-1:0]   meta;
  } cell_t;

  localparam logic [TID_W-1:0] TID_NONE = '1;

  function automatic cell_t cell_reset();
    cell_t c;
    c.st   = ST_EMPTY;
    c.data = '0;
    c.head = TID_NONE;
    c.tail = TID_NONE;
    c.meta = '0;
    return c;
  endfunction

  // An emptied or pending cell must not name a waiting thread.
  function automatic logic head_rule_broken(sync_st_e nst, logic [TID_W-1:0] nhead);
    return (nst == ST_EMPTY || nst == ST_PENDING) && (nhead != TID_NONE);
  endfunction

  // A waiting cell may not fall back to empty.
  function automatic logic unwait_broken(cell_t old, sync_st_e nst);
    return (old.st == ST_WAITING) && (nst == ST_EMPTY);
  endfunction

  // A pending load tag may only be touched by the memory return path.
  function automatic logic meta_broken(cell_t old, sync_st_e nst,
                                       logic [META_W-1:0] nmeta, logic from_mem);
    return (old.meta != '0) && !from_mem && (nst == ST_FULL || nmeta != old.meta);
  endfunction

  function automatic logic wake_needed(cell_t old, sync_st_e nst);
    return (old.st == ST_WAITING) && (old.head != TID_NONE) && (nst == ST_FULL);
  endfunction
endpackage

// File: rtl/dfsync_bank.sv
module dfsync_bank
  import dfsync_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NWP   = 2,
  parameter int NLK   = 3,
  parameter int IW    = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWP-1:0]           we,
  input  logic [NWP-1:0][IW-1:0]   widx,
  input  cell_t [NWP-1:0]          wcell,
  input  logic [NLK-1:0][IW-1:0]   lk_idx,
  output cell_t [NLK-1:0]          lk_cell
);
  cell_t cur [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    cell_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= cell_reset();
      end else begin
        for (int p = 0; p < NWP; p++) begin
          if (we[p] && widx[p] == IW'(e)) q <= wcell[p];
        end
      end
    end
    assign cur[e] = q;
  end

  always_comb begin
    for (int l = 0; l < NLK; l++) begin
      if (int'(lk_idx[l]) < DEPTH) lk_cell[l] = cur[lk_idx[l][AW-1:0]];
      else                         lk_cell[l] = cell_reset();
    end
  end
endmodule

// File: rtl/dfsync_wcheck.sv
module dfsync_wcheck
  import dfsync_pkg::*;
(
  input  logic              valid,
  input  logic              in_range,
  input  logic              dup,
  input  cell_t             old,
  input  sync_st_e          nst,
  input  logic [TID_W-1:0]  nhead,
  input  logic [META_W-1:0] nmeta,
  input  logic              from_mem,
  output logic              ev_range,
  output logic              ev_dup,
  output logic              ev_proto,
  output logic              want_wake,
  output logic              clear_to_write
);
  logic proto, live;

  always_comb begin
    proto = head_rule_broken(nst, nhead) ||
            (old.st != ST_FULL &&
             (unwait_broken(old, nst) || meta_broken(old, nst, nmeta, from_mem)));
    live           = valid && in_range && !dup;
    ev_range       = valid && !in_range;
    ev_dup         = valid && in_range && dup;
    ev_proto       = live && proto;
    clear_to_write = live && !proto;
    want_wake      = clear_to_write && wake_needed(old, nst);
  end
endmodule

// File: rtl/dfsync_regfile.sv
module dfsync_regfile
  import dfsync_pkg::*;
#(
  parameter int INT_DEPTH = 16,
  parameter int FLT_DEPTH = 8,
  parameter int NWP       = 2,
  localparam int MAXD     = (INT_DEPTH > FLT_DEPTH) ? INT_DEPTH : FLT_DEPTH,
  localparam int IW       = (MAXD > 1) ? $clog2(MAXD) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NWP-1:0]                wr_valid,
  input  logic [NWP-1:0]                wr_bank,
  input  logic [NWP-1:0][IW-1:0]        wr_index,
  input  logic [NWP-1:0][1:0]           wr_state,
  input  logic [NWP-1:0][DATA_W-1:0]    wr_data,
  input  logic [NWP-1:0][TID_W-1:0]     wr_head,
  input  logic [NWP-1:0][TID_W-1:0]     wr_tail,
  input  logic [NWP-1:0][META_W-1:0]    wr_meta,
  input  logic [NWP-1:0]                wr_from_mem,
  output logic [NWP-1:0]                wr_accept,
  output logic                          wake_valid,
  input  logic                          wake_ready,
  output logic [TID_W-1:0]              wake_head,
  output logic [TID_W-1:0]              wake_tail,
  input  logic                          rd_bank,
  input  logic [IW-1:0]                 rd_index,
  output logic [1:0]                    rd_state,
  output logic [DATA_W-1:0]             rd_data,
  output logic [TID_W-1:0]              rd_head,
  output logic [TID_W-1:0]              rd_tail,
  output logic [META_W-1:0]             rd_meta,
  output logic                          err_range,
  output logic                          err_dup,
  output logic                          err_proto
);
  localparam int NLK = NWP + 1;
  localparam int GW  = (NWP > 1) ? $clog2(NWP) : 1;

  logic [NLK-1:0][IW-1:0] lk_idx;
  cell_t [NLK-1:0]        int_cell, flt_cell;
  cell_t [NWP-1:0]        new_cell;
  cell_t                  old_c [NWP];
  cell_t                  rd_cell;
  logic [NWP-1:0]         in_range, dup, int_we, flt_we;
  logic [NWP-1:0]         ev_range, ev_dup, ev_proto, want_wake, clear;
  logic                   grant_any;
  logic [GW-1:0]          grant;

  always_comb begin
    for (int p = 0; p < NWP; p++) lk_idx[p] = wr_index[p];
    lk_idx[NWP] = rd_index;
  end

  dfsync_bank #(.DEPTH(INT_DEPTH), .NWP(NWP), .NLK(NLK), .IW(IW)) u_int_bank (
    .clk(clk), .rst_n(rst_n), .we(int_we), .widx(wr_index), .wcell(new_cell),
    .lk_idx(lk_idx), .lk_cell(int_cell));

  dfsync_bank #(.DEPTH(FLT_DEPTH), .NWP(NWP), .NLK(NLK), .IW(IW)) u_flt_bank (
    .clk(clk), .rst_n(rst_n), .we(flt_we), .widx(wr_index), .wcell(new_cell),
    .lk_idx(lk_idx), .lk_cell(flt_cell));

  // Per-port address decode and same-cycle collision detection.
  always_comb begin
    dup = '0;
    for (int p = 0; p < NWP; p++) begin
      in_range[p] = wr_bank[p] ? (int'(wr_index[p]) < FLT_DEPTH)
                               : (int'(wr_index[p]) < INT_DEPTH);
      old_c[p]    = wr_bank[p] ? flt_cell[p] : int_cell[p];
      new_cell[p].st   = sync_st_e'(wr_state[p]);
      new_cell[p].data = wr_data[p];
      new_cell[p].head = wr_head[p];
      new_cell[p].tail = wr_tail[p];
      new_cell[p].meta = wr_meta[p];
      for (int q = 0; q < NWP; q++) begin
        if (q < p && wr_valid[q] && wr_bank[q] == wr_bank[p] && wr_index[q] == wr_index[p])
          dup[p] = 1'b1;
      end
    end
  end

  for (genvar p = 0; p < NWP; p++) begin : g_chk
    dfsync_wcheck u_chk (
      .valid(wr_valid[p]), .in_range(in_range[p]), .dup(dup[p]), .old(old_c[p]),
      .nst(sync_st_e'(wr_state[p])), .nhead(wr_head[p]), .nmeta(wr_meta[p]),
      .from_mem(wr_from_mem[p]), .ev_range(ev_range[p]), .ev_dup(ev_dup[p]),
      .ev_proto(ev_proto[p]), .want_wake(want_wake[p]), .clear_to_write(clear[p]));
  end

  // Lowest port needing a wake-up owns the single request.
  always_comb begin
    grant_any = 1'b0;
    grant     = '0;
    for (int p = 0; p < NWP; p++) begin
      if (want_wake[p] && !grant_any) begin
        grant_any = 1'b1;
        grant     = GW'(p);
      end
    end
    wake_valid = grant_any;
    wake_head  = old_c[grant].head;
    wake_tail  = old_c[grant].tail;
    for (int p = 0; p < NWP; p++) begin
      wr_accept[p] = clear[p] && (!want_wake[p] || (grant == GW'(p) && wake_ready));
      int_we[p]    = wr_accept[p] && !wr_bank[p];
      flt_we[p]    = wr_accept[p] &&  wr_bank[p];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_range <= 1'b0;
      err_dup   <= 1'b0;
      err_proto <= 1'b0;
    end else begin
      err_range <= err_range | (|ev_range);
      err_dup   <= err_dup   | (|ev_dup);
      err_proto <= err_proto | (|ev_proto);
    end
  end

  always_comb begin
    rd_cell  = rd_bank ? flt_cell[NWP] : int_cell[NWP];
    rd_state = rd_cell.st;
    rd_data  = rd_cell.data;
    rd_head  = rd_cell.head;
    rd_tail  = rd_cell.tail;
    rd_meta  = rd_cell.meta;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past({err_range, err_dup, err_proto}) & ~{err_range, err_dup, err_proto}) == 3'b000)); // R10

  AST_WAKE_HAS_THREAD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_head != TID_NONE)); // R4

  AST_COMMIT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept[0] && rd_bank == wr_bank[0] && rd_index == wr_index[0])
    |=> (!$stable({rd_bank, rd_index}) || rd_state == $past(wr_state[0]))); // R3

  for (genvar p = 0; p < NWP; p++) begin : g_ast
    AST_EMPTY_HEAD_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept[p] && wr_state[p] <= 2'd1) |-> (wr_head[p] == TID_NONE)); // R5
    for (genvar q = p + 1; q < NWP; q++) begin : g_pair
      AST_NO_SHARED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept[p] && wr_accept[q]) |-> ({wr_bank[p], wr_index[p]} != {wr_bank[q], wr_index[q]})); // R9
    end
  end
endmodule

// File: tb/dfsync_regfile_tb_top.sv
module dfsync_regfile_tb_top;
  import dfsync_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int NWP = 2;
  localparam int IDEP = 16;
  localparam int FDEP = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NWP-1:0]             wr_valid, wr_bank, wr_from_mem, wr_accept;
  logic [NWP-1:0][IW-1:0]     wr_index;
  logic [NWP-1:0][1:0]        wr_state;
  logic [NWP-1:0][DATA_W-1:0] wr_data;
  logic [NWP-1:0][TID_W-1:0]  wr_head, wr_tail;
  logic [NWP-1:0][META_W-1:0] wr_meta;
  logic wake_valid, wake_ready;
  logic [TID_W-1:0] wake_head, wake_tail, rd_head, rd_tail;
  logic rd_bank;
  logic [IW-1:0] rd_index;
  logic [1:0] rd_state;
  logic [DATA_W-1:0] rd_data;
  logic [META_W-1:0] rd_meta;
  logic err_range, err_dup, err_proto;

  dfsync_regfile #(.INT_DEPTH(IDEP), .FLT_DEPTH(FDEP), .NWP(NWP)) dut_i (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  cell_t m_int [IDEP];
  cell_t m_flt [FDEP];
  logic [2:0] m_flags;
  logic [NWP-1:0] exp_acc;
  logic exp_wv;
  logic [TID_W-1:0] exp_wh, exp_wt;
  logic [2:0] exp_ev;
  string why [NWP];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic cell_t mget(logic bank, logic [IW-1:0] idx);
    cell_t r;
    r.st = ST_EMPTY; r.data = '0; r.head = '1; r.tail = '1; r.meta = '0;
    if (bank == 1'b0 && int'(idx) < IDEP) r = m_int[idx];
    if (bank == 1'b1 && int'(idx) < FDEP) r = m_flt[idx[2:0]];
    return r;
  endfunction

  // Independent statement of the acceptance rules.
  task automatic predict();
    logic taken;
    exp_wv = 1'b0; exp_wh = '0; exp_wt = '0; exp_ev = '0; exp_acc = '0; taken = 1'b0;
    for (int p = 0; p < NWP; p++) begin
      cell_t o;
      logic lim, col, bad, wk;
      o = mget(wr_bank[p], wr_index[p]);
      why[p] = "R3 R11 accept";
      lim = wr_bank[p] ? (wr_index[p] >= FDEP) : (wr_index[p] >= IDEP);
      col = 1'b0;
      for (int q = 0; q < p; q++)
        if (wr_valid[q] && wr_bank[q] == wr_bank[p] && wr_index[q] == wr_index[p]) col = 1'b1;
      bad = 1'b0;
      if (wr_state[p] < 2'd2 && wr_head[p] != 4'hF) begin bad = 1'b1; why[p] = "R5 accept"; end
      if (o.st != ST_FULL) begin
        if (o.st == ST_WAITING && wr_state[p] == 2'd0) begin bad = 1'b1; why[p] = "R6 accept"; end
        if (o.meta != 0 && !wr_from_mem[p] && (wr_state[p] == 2'd3 || wr_meta[p] != o.meta)) begin
          bad = 1'b1; why[p] = "R7 accept";
        end
      end
      wk = (o.st == ST_WAITING) && (o.head != 4'hF) && (wr_state[p] == 2'd3);
      if (!wr_valid[p]) begin
        why[p] = "R3 idle";
      end else if (lim) begin
        exp_ev[2] = 1'b1; why[p] = "R8 accept";
      end else if (col) begin
        exp_ev[1] = 1'b1; why[p] = "R9 accept";
      end else if (bad) begin
        exp_ev[0] = 1'b1;
      end else if (wk) begin
        why[p] = "R4 accept";
        if (!taken) begin
          taken = 1'b1; exp_wv = 1'b1; exp_wh = o.head; exp_wt = o.tail;
          exp_acc[p] = wake_ready;
        end
      end else begin
        exp_acc[p] = 1'b1;
      end
    end
  endtask

  task automatic step();
    cell_t e;
    #1;
    predict();
    e = mget(rd_bank, rd_index);
    check("R2 R3 read", {18'd0, rd_state, rd_data, rd_head, rd_tail, rd_meta}, {18'd0, e});
    check("R10 R5 R8 R9 flags", {61'd0, err_range, err_dup, err_proto}, {61'd0, m_flags});
    for (int p = 0; p < NWP; p++) check(why[p], {63'd0, wr_accept[p]}, {63'd0, exp_acc[p]});
    check("R4 wake", {55'd0, wake_valid, (exp_wv ? {wake_head, wake_tail} : 8'd0)},
                     {55'd0, exp_wv, exp_wh, exp_wt});
    @(posedge clk);
    for (int p = 0; p < NWP; p++) begin
      if (exp_acc[p]) begin
        cell_t c;
        c.st = sync_st_e'(wr_state[p]); c.data = wr_data[p];
        c.head = wr_head[p]; c.tail = wr_tail[p]; c.meta = wr_meta[p];
        if (wr_bank[p]) m_flt[wr_index[p][2:0]] = c;
        else            m_int[wr_index[p]] = c;
      end
    end
    m_flags = m_flags | {exp_ev[2], exp_ev[1], exp_ev[0]};
    @(negedge clk);
  endtask

  task automatic idle();
    wr_valid = '0; wr_bank = '0; wr_index = '0; wr_state = '0; wr_data = '0;
    wr_head = '1; wr_tail = '1; wr_meta = '0; wr_from_mem = '0; wake_ready = 1'b1;
  endtask

  task automatic put(int p, logic b, int idx, int st, logic [31:0] d,
                     int hd, int tl, int mt, logic mem);
    wr_valid[p] = 1'b1; wr_bank[p] = b; wr_index[p] = IW'(idx);
    wr_state[p] = 2'(st); wr_data[p] = d; wr_head[p] = 4'(hd);
    wr_tail[p] = 4'(tl); wr_meta[p] = 4'(mt); wr_from_mem[p] = mem;
  endtask

  task automatic rand_inputs();
    for (int p = 0; p < NWP; p++) begin
      wr_valid[p]    = ($urandom_range(0, 3) != 0);
      wr_bank[p]     = $urandom_range(0, 1);
      wr_index[p]    = IW'($urandom_range(0, 9));
      wr_state[p]    = 2'($urandom_range(0, 3));
      wr_data[p]     = $urandom;
      wr_head[p]     = ($urandom_range(0, 9) < 6) ? 4'hF : 4'($urandom_range(0, 14));
      wr_tail[p]     = 4'($urandom_range(0, 15));
      wr_meta[p]     = ($urandom_range(0, 9) < 6) ? 4'h0 : 4'($urandom_range(1, 3));
      wr_from_mem[p] = ($urandom_range(0, 9) < 3);
    end
    wake_ready = ($urandom_range(0, 9) < 7);
    rd_bank    = $urandom_range(0, 1);
    rd_index   = IW'($urandom_range(0, 9));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < IDEP; i++) m_int[i] = '{st: ST_EMPTY, data: '0, head: '1, tail: '1, meta: '0};
    for (int i = 0; i < FDEP; i++) m_flt[i] = '{st: ST_EMPTY, data: '0, head: '1, tail: '1, meta: '0};
    m_flags = '0;
    idle();
    rd_bank = 1'b0; rd_index = '0;
    repeat (3) @(negedge clk);
    // R1: reset state seen at the read port during reset
    check("R1 reset state", {62'd0, rd_state}, 64'd0);
    check("R1 reset head", {60'd0, rd_head}, 64'hF);
    check("R1 reset flags", {61'd0, err_range, err_dup, err_proto}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_index = 4'd15; step();
    rd_bank = 1'b1; rd_index = 4'd7; step();
    rd_index = 4'd9; step();                       // R2 out-of-range read
    rd_bank = 1'b0; rd_index = 4'd3;
    put(0, 0, 3, 2, 32'h0, 2, 5, 0, 0); step();    // becomes WAITING
    put(0, 0, 3, 3, 32'hAAAA5555, 15, 15, 0, 0);
    wake_ready = 1'b0; step();                     // R4 refused, not ready
    wake_ready = 1'b1; step();                     // R4 accepted with wake
    idle(); rd_index = 4'd4;
    put(0, 0, 4, 1, 32'h1, 15, 15, 0, 0);
    put(1, 0, 4, 1, 32'h2, 15, 15, 0, 0); step();  // R9 collision
    idle(); rd_index = 4'd6;
    put(0, 0, 6, 2, 32'h0, 1, 1, 0, 0); step();
    put(0, 0, 6, 0, 32'h0, 15, 15, 0, 0); step();  // R6
    idle(); rd_index = 4'd7;
    put(0, 0, 7, 1, 32'h0, 15, 15, 3, 0); step();
    put(0, 0, 7, 3, 32'h77, 15, 15, 3, 0); step(); // R7 refused
    put(0, 0, 7, 3, 32'h77, 15, 15, 0, 1); step(); // R7 memory path allowed
    put(0, 0, 7, 0, 32'h0, 15, 15, 0, 0); step();  // R11 FULL entry rewritten
    idle();
    put(0, 1, 12, 3, 32'h5, 15, 15, 0, 0); step(); // R8
    put(0, 0, 8, 0, 32'h0, 3, 3, 0, 0); step();    // R5
    idle(); rd_index = 4'd9;
    put(0, 0, 9, 2, 32'h0, 1, 1, 0, 0);
    put(1, 1, 2, 2, 32'h0, 4, 6, 0, 0); step();
    put(0, 0, 9, 3, 32'h9, 15, 15, 0, 0);
    put(1, 1, 2, 3, 32'h2, 15, 15, 0, 0); step();  // R4 lowest port owns wake
    idle();
    for (int n = 0; n < 3000; n++) begin
      rand_inputs();
      step();
    end
    idle(); step();                                 // R10 flags still held
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule